// File: doc/BRIEF.md
# Write-Allocate Policy Unit

This unit sits beside an L1 data cache and answers one question for each write that is presented to it: should a cache line be allocated for this store? A 64-bit control register, written and read over a plain one-register bus, holds two settings. The first is a 10-bit limit field scaled in 4 Mbyte units, placing a ceiling on the memory that allocates through the address-limit path. The second is an enable bit that lets that same path allocate inside the 1 Mbyte window starting at 15 Mbytes.

Each request carries a 32-bit physical address and four flags. One flag says the write hit in L1. Two are hints from elsewhere in the memory system: the write targets a cacheable page, or it falls in a sector already present. The last says the address lies in a region where limit-based allocation is forbidden. A hint overrides the limit path, the forbidden-region flag and the window rule. An L1 hit never allocates.

Requests use a valid/ready handshake. The allocate result appears on a registered response port one cycle after acceptance, and it is held until the consumer takes it.

Top module: `wralloc_policy`

## Requirements
- R1: After reset the control register reads back as all zeros, and no response is valid.
- R2: Register bits 31:22 (limit field) and bit 16 (window enable) store the written value. Every other bit ignores writes and reads as zero.
- R3: A write that misses L1, carries no hint, is not forbidden, and has addr[31:22] below the limit field is allocated, provided it lies outside the 15–16 Mbyte window.
- R4: A miss with no hint whose addr[31:22] is at or above the limit field is not allocated. A limit field of zero therefore never allocates through the limit path.
- R5: A miss with no hint whose address lies in [15 Mbyte, 16 Mbyte) and is below the limit allocates only when the window enable bit is 1.
- R6: A miss with the page hint or the sector hint (or both) is allocated, whatever the limit, the window bit or the forbidden flag say.
- R7: The forbidden-region input stops allocation through the limit path only. It does not stop allocation forced by a hint.
- R8: A request that hits in L1 always returns no-allocate, hints included.
- R9: The response is valid in the cycle after a request is accepted (req_valid and req_ready both high at a clock edge). It is computed with the register contents in effect at that edge, so a register write in the same cycle does not affect it.
- R10: While rsp_valid is high and rsp_ready is low, req_ready is low and rsp_alloc holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Control register write strobe |
| csr_wdata | input | 64 | Control register write data |
| csr_rdata | output | 64 | Control register read data |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_addr | input | 32 | Physical write address |
| req_l1_hit | input | 1 | Write hit in L1 |
| req_page_hint | input | 1 | Target page is cacheable |
| req_sector_hint | input | 1 | Target sector already resident |
| req_blocked | input | 1 | Address in a forbidden-for-limit region |
| rsp_valid | output | 1 | Decision present |
| rsp_ready | input | 1 | Consumer takes the decision |
| rsp_alloc | output | 1 | 1 = allocate a line |

## Verification
The first sweep walks the address space in 1 Mbyte steps for limit values of 0, 4, 5 and 1023, each with the window bit clear and set. This separates below-limit from at-or-above-limit at the exact granule boundary. It also separates the 15 Mbyte window from its neighbours, and a zero field from the largest one. The second sweep crosses the low 64 Mbytes with all sixteen combinations of hit, both hints and the forbidden flag, which shows hint override, forbidden-flag reach and hit dominance apart. Directed cases cover a register write landing in the acceptance cycle, a stalled consumer, and reserved-bit readback.

// File: rtl/wralloc_pkg.sv
package wralloc_pkg;
   localparam int CSR_W = 64;

   typedef struct packed {
      logic l1_hit;
      logic page_hint;
      logic sector_hint;
      logic blocked;
   } wa_attr_t;

   function automatic logic wa_combine(input wa_attr_t a, input logic limit_ok);
      if (a.l1_hit) return 1'b0;
      if (a.page_hint || a.sector_hint) return 1'b1;
      return limit_ok && !a.blocked;
   endfunction
endpackage

// File: rtl/wralloc_csr.sv
module wralloc_csr #(
   parameter int CSR_W      = 64,
   parameter int LIM_W      = 10,
   parameter int LIM_LSB    = 22,
   parameter int HOLE_BIT   = 16,
   parameter bit HOLE_CHECK = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CSR_W-1:0] wdata,
   output logic [CSR_W-1:0] rdata,
   output logic [LIM_W-1:0] lim,
   output logic             hole_en
);
   localparam int LIM_MSB = LIM_LSB + LIM_W - 1;

   if (LIM_MSB >= CSR_W) begin : g_bad_field
      $error("limit field exceeds register width");
   end
   if (HOLE_BIT >= LIM_LSB && HOLE_BIT <= LIM_MSB) begin : g_bad_bit
      $error("window bit overlaps limit field");
   end

   logic [LIM_W-1:0] lim_q;
   logic             en_q;
   logic             unused_wbits;

   assign unused_wbits = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lim_q <= '0;
      else if (we) lim_q <= wdata[LIM_MSB:LIM_LSB];
   end

   if (HOLE_CHECK) begin : g_en
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) en_q <= 1'b0;
         else if (we) en_q <= wdata[HOLE_BIT];
      end
   end else begin : g_no_en
      assign en_q = 1'b0;
   end

   always_comb begin
      rdata = '0;
      rdata[LIM_MSB:LIM_LSB] = lim_q;
      rdata[HOLE_BIT] = en_q;
   end

   assign lim     = lim_q;
   assign hole_en = en_q;

   p_field_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> lim == $past(wdata[LIM_MSB:LIM_LSB]));
   p_field_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(rdata));
endmodule

// File: rtl/wralloc_region.sv
module wralloc_region #(
   parameter int ADDR_W     = 32,
   parameter int LIM_W      = 10,
   parameter int GRAN_SHIFT = 22,
   parameter int MB_SHIFT   = 20,
   parameter int HOLE_LO_MB = 15,
   parameter int HOLE_HI_MB = 16,
   parameter bit HOLE_CHECK = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [LIM_W-1:0]  lim,
   input  logic              hole_en,
   output logic              limit_ok
);
   localparam int SLICE_W = ADDR_W - GRAN_SHIFT;
   localparam logic [ADDR_W-1:0] HOLE_LO = ADDR_W'(longint'(HOLE_LO_MB) << MB_SHIFT);
   localparam logic [ADDR_W-1:0] HOLE_HI = ADDR_W'(longint'(HOLE_HI_MB) << MB_SHIFT);

   if (SLICE_W != LIM_W) begin : g_bad_slice
      $error("limit field width must match the address granule slice");
   end
   if (HOLE_HI_MB <= HOLE_LO_MB) begin : g_bad_hole
      $error("window upper bound must exceed lower bound");
   end

   logic below;
   logic in_hole;

   assign below = addr[ADDR_W-1:GRAN_SHIFT] < lim;

   if (HOLE_CHECK) begin : g_hole
      assign in_hole = (addr >= HOLE_LO) && (addr < HOLE_HI);
   end else begin : g_no_hole
      assign in_hole = 1'b0;
   end

   assign limit_ok = below && (!in_hole || hole_en);

   always_comb begin
      if (lim == '0) a_zero_lim_r4: assert (!limit_ok);
   end
endmodule

// File: rtl/wralloc_resp.sv
module wralloc_resp
   import wralloc_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     req_valid,
   output logic     req_ready,
   input  wa_attr_t attr,
   input  logic     limit_ok,
   output logic     rsp_valid,
   input  logic     rsp_ready,
   output logic     rsp_alloc
);
   logic accept;
   logic alloc_d;

   assign req_ready = !rsp_valid || rsp_ready;
   assign accept    = req_valid && req_ready;
   assign alloc_d   = wa_combine(attr, limit_ok);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_alloc <= 1'b0;
      end else if (accept) begin
         rsp_valid <= 1'b1;
         rsp_alloc <= alloc_d;
      end else if (rsp_ready) begin
         rsp_valid <= 1'b0;
      end
   end

   p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> rsp_valid);
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_alloc)));
endmodule

// File: rtl/wralloc_policy.sv
module wralloc_policy
   import wralloc_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LIM_W      = 10,
   parameter int LIM_LSB    = 22,
   parameter int HOLE_BIT   = 16,
   parameter bit HOLE_CHECK = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             csr_we,
   input  logic [CSR_W-1:0] csr_wdata,
   output logic [CSR_W-1:0] csr_rdata,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic             req_l1_hit,
   input  logic             req_page_hint,
   input  logic             req_sector_hint,
   input  logic             req_blocked,
   output logic             rsp_valid,
   input  logic             rsp_ready,
   output logic             rsp_alloc
);
   logic [LIM_W-1:0] lim;
   logic             hole_en;
   logic             limit_ok;
   wa_attr_t         attr;

   assign attr = '{l1_hit: req_l1_hit, page_hint: req_page_hint,
                   sector_hint: req_sector_hint, blocked: req_blocked};

   wralloc_csr #(
      .CSR_W(CSR_W), .LIM_W(LIM_W), .LIM_LSB(LIM_LSB),
      .HOLE_BIT(HOLE_BIT), .HOLE_CHECK(HOLE_CHECK)
   ) u_csr (
      .clk(clk), .rst_n(rst_n), .we(csr_we), .wdata(csr_wdata),
      .rdata(csr_rdata), .lim(lim), .hole_en(hole_en)
   );

   wralloc_region #(
      .ADDR_W(ADDR_W), .LIM_W(LIM_W), .GRAN_SHIFT(LIM_LSB),
      .HOLE_CHECK(HOLE_CHECK)
   ) u_region (
      .addr(req_addr), .lim(lim), .hole_en(hole_en), .limit_ok(limit_ok)
   );

   wralloc_resp u_resp (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .attr(attr), .limit_ok(limit_ok), .rsp_valid(rsp_valid),
      .rsp_ready(rsp_ready), .rsp_alloc(rsp_alloc)
   );

   p_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_l1_hit) |=> !rsp_alloc);
   p_hint_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !req_l1_hit && (req_page_hint || req_sector_hint))
      |=> rsp_alloc);
   p_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_blocked && !req_page_hint && !req_sector_hint)
      |=> !rsp_alloc);
   p_zero_lim_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && lim == '0 && !req_page_hint && !req_sector_hint)
      |=> !rsp_alloc);
endmodule

// File: tb/wralloc_policy_test.sv
module wralloc_policy_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_we = 1'b0;
   logic [63:0] csr_wdata = '0;
   logic [63:0] csr_rdata;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic        req_l1_hit = 1'b0;
   logic        req_page_hint = 1'b0;
   logic        req_sector_hint = 1'b0;
   logic        req_blocked = 1'b0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b1;
   logic        rsp_alloc;

   int checks = 0;
   int fails  = 0;
   int cur_lim = 0;
   bit cur_en  = 1'b0;

   always #2 clk = ~clk;

   wralloc_policy uut (
      .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
      .csr_rdata(csr_rdata), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_l1_hit(req_l1_hit), .req_page_hint(req_page_hint),
      .req_sector_hint(req_sector_hint), .req_blocked(req_blocked),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_alloc(rsp_alloc)
   );

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic bit model(input logic [31:0] a, input bit hit, input bit pg,
                                input bit sec, input bit blk, input int lim, input bit en);
      longint unsigned ceil_b = longint'(lim) * 64'd4194304;
      bit below = longint'(a) < ceil_b;
      bit hole  = (a >= 32'd15728640) && (a < 32'd16777216);
      if (hit) return 1'b0;
      if (pg || sec) return 1'b1;
      if (blk) return 1'b0;
      return below && (!hole || en);
   endfunction

   function automatic string tag_of(input logic [31:0] a, input bit hit, input bit pg,
                                    input bit sec, input bit blk, input int lim);
      if (hit) return "R8";
      if (pg || sec) return "R6";
      if (blk) return "R7";
      if (a >= 32'd15728640 && a < 32'd16777216) return "R5";
      if (longint'(a) < longint'(lim) * 64'd4194304) return "R3";
      return "R4";
   endfunction

   task automatic csr_write(input int lim, input bit en, input logic [63:0] noise);
      @(negedge clk);
      csr_we = 1'b1;
      csr_wdata = noise;
      csr_wdata[31:22] = lim[9:0];
      csr_wdata[16] = en;
      @(negedge clk);
      csr_we = 1'b0;
      cur_lim = lim;
      cur_en = en;
   endtask

   task automatic request(input logic [31:0] a, input bit hit, input bit pg,
                          input bit sec, input bit blk);
      bit exp = model(a, hit, pg, sec, blk, cur_lim, cur_en);
      @(negedge clk);
      req_valid = 1'b1;
      req_addr = a;
      req_l1_hit = hit;
      req_page_hint = pg;
      req_sector_hint = sec;
      req_blocked = blk;
      @(negedge clk);
      req_valid = 1'b0;
      check(rsp_valid === 1'b1, "R9 valid", longint'(rsp_valid), 1);
      check(rsp_alloc === exp, tag_of(a, hit, pg, sec, blk, cur_lim),
            longint'(rsp_alloc), longint'(exp));
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int lims[4] = '{0, 4, 5, 1023};
      repeat (3) @(negedge clk);
      // R1: reset state
      check(csr_rdata === 64'h0, "R1 rdata", longint'(csr_rdata), 0);
      check(rsp_valid === 1'b0, "R1 rsp_valid", longint'(rsp_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(csr_rdata === 64'h0, "R1 rdata after release", longint'(csr_rdata), 0);

      // R2: reserved bits ignored, fields stored
      csr_write(1023, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
      check(csr_rdata === 64'h0000_0000_FFC1_0000, "R2 all ones",
            longint'(csr_rdata), 64'h0000_0000_FFC1_0000);
      csr_write(5, 1'b0, 64'hA5A5_A5A5_003E_FFFF);
      check(csr_rdata === 64'h0000_0000_0140_0000, "R2 pattern",
            longint'(csr_rdata), 64'h0000_0000_0140_0000);

      // R3 R4 R5: address sweep in 1 MB steps over several limits
      foreach (lims[k]) begin
         for (int e = 0; e < 2; e++) begin
            csr_write(lims[k], e[0], 64'h0);
            for (int i = 0; i < 4096; i++) begin
               logic [31:0] a = {i[11:0], 20'(i * 37)};
               request(a, 1'b0, 1'b0, 1'b0, 1'b0);
            end
         end
      end

      // R6 R7 R8: flag combinations across the low 64 MB
      for (int e = 0; e < 2; e++) begin
         csr_write(8, e[0], 64'h0);
         for (int i = 0; i < 64; i++) begin
            for (int c = 0; c < 16; c++) begin
               request({i[11:0], 20'h0_0400}, c[3], c[2], c[1], c[0]);
            end
         end
      end

      // R9: register written in the acceptance cycle is not used
      csr_write(8, 1'b1, 64'h0);
      @(negedge clk);
      csr_we = 1'b1;
      csr_wdata = 64'h0;
      req_valid = 1'b1;
      req_addr = 32'h0010_0000;
      req_l1_hit = 1'b0; req_page_hint = 1'b0; req_sector_hint = 1'b0; req_blocked = 1'b0;
      @(negedge clk);
      csr_we = 1'b0;
      req_valid = 1'b0;
      cur_lim = 0; cur_en = 1'b0;
      check(rsp_alloc === 1'b1, "R9 old limit used", longint'(rsp_alloc), 1);
      request(32'h0010_0000, 1'b0, 1'b0, 1'b0, 1'b0);

      // R10: stalled consumer
      @(negedge clk);
      rsp_ready = 1'b0;
      req_valid = 1'b1;
      req_page_hint = 1'b1;
      @(negedge clk);
      req_page_hint = 1'b0;
      req_l1_hit = 1'b1;
      repeat (3) @(negedge clk);
      check(req_ready === 1'b0, "R10 ready low", longint'(req_ready), 0);
      check(rsp_valid === 1'b1, "R10 valid held", longint'(rsp_valid), 1);
      check(rsp_alloc === 1'b1, "R10 alloc held", longint'(rsp_alloc), 1);
      req_valid = 1'b0;
      req_l1_hit = 1'b0;
      rsp_ready = 1'b1;
      @(negedge clk);
      check(rsp_valid === 1'b0, "R10 drained", longint'(rsp_valid), 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule